// File: doc/BRIEF.md
# Event-Driven Task Scheduler

This block decides which of a small set of per-core tasks runs next. Each task carries two state bits, *activated* and *blocked*, and is eligible to run only while it is activated and not blocked. Software commands and hardware events set or clear these bits. Two kinds of hardware event exist: a data word arriving on a channel, and a background thread finishing its work.

Every thread-completion input is routed to one task and either activates it or unblocks it. Because the two bits are independent, two unrelated completions can be wired to the same task, one activating it and one unblocking it. The task then runs only after both have happened. A barrier task re-blocks itself with a command when it runs, so a chain of such two-input barriers can merge many completions into one.

The scheduler presents one eligible task at a time on a valid/ready dispatch port. High-priority tasks are offered first, and ties go to the lowest index. An accepted task occupies the core until the core pulses `task_done`. On the next cycle the scheduler offers the next eligible task.

Top module: `task_sched`

## Requirements
- R1: `disp_valid` is high only when the scheduler is idle and at least one task has activated=1 and blocked=0, and `disp_task` then names such a task.
- R2: After reset no task is activated, `disp_valid` is low, and the tasks whose bit is set in `RESET_BLOCKED` (default: tasks 8 to 15) start blocked. Activating such a task does not make it eligible.
- R3: `cmd_op` encodings take effect at the next clock edge on task `cmd_task`: 2'b00 does nothing, 2'b01 activates, 2'b10 blocks, 2'b11 unblocks.
- R4: A high bit `chan_word[c]` activates the task whose index is held in `chan_map[c*TID_W +: TID_W]`.
- R5: A high bit `thr_done[k]` acts on the task held in `thr_map[k*TID_W +: TID_W]`. It activates that task when `thr_unblk[k]` is 0 and unblocks it when `thr_unblk[k]` is 1.
- R6: When any eligible task has its bit set in `prio_mask`, the offered task is one of those high-priority tasks.
- R7: Among eligible tasks of the same priority class, the lowest index is offered.
- R8: A dispatch is accepted when `disp_valid` and `disp_ready` are both high at a clock edge. Acceptance clears that task's activated bit and leaves its blocked bit unchanged. If an activate event hits the same task in that cycle, the bit stays set. The scheduler is then busy with `disp_valid` low until `task_done` is seen at an edge, and the next task can be offered in the cycle right after that edge.
- R9: All events and the command that hit the tasks in one cycle are applied together. If one task receives both a block and an unblock in the same cycle, it ends up blocked. Any activation in that cycle is still kept.
- R10: `task_done` while idle and `disp_ready` while `disp_valid` is low are both ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 2 | Command code (R3) |
| cmd_task | input | TID_W | Command target task |
| chan_word | input | NUM_CHANNELS | One-cycle pulse per channel when a word arrives |
| chan_map | input | NUM_CHANNELS*TID_W | Task bound to each channel |
| thr_done | input | NUM_THREADS | One-cycle pulse per background thread on completion |
| thr_map | input | NUM_THREADS*TID_W | Target task of each thread completion |
| thr_unblk | input | NUM_THREADS | Per thread: 1 unblocks the target, 0 activates it |
| prio_mask | input | NUM_TASKS | High-priority tasks |
| disp_valid | output | 1 | A task is offered |
| disp_ready | input | 1 | Core takes the offered task |
| disp_task | output | TID_W | Offered task index |
| task_done | input | 1 | Running task has finished |

Back-pressure rule: while `disp_ready` is low, the offer is re-evaluated every cycle. It may switch to a newly eligible task of higher rank, or drop if its task is blocked. The core takes whatever task is shown in the cycle it raises `disp_ready`.

## Verification
The selection is exercised with three kinds of pattern: a single source at a time, several pending tasks of equal priority, and a high-priority task competing against lower-indexed normal tasks. The first kind confirms that each source reaches its mapped task. The second tells lowest-index order apart from arrival order. The third tells priority apart from index order. The barrier patterns deliver an activate and an unblock from two threads in separate cycles and then in the same cycle. A block command and an unblock event are also made to collide on one task, which separates the set-wins rule from a last-writer rule. Dispatch sequences overlap acceptance with a fresh activation, pulse `task_done` while idle and pulse `disp_ready` with no offer, to show that the busy flag and the activated bits move only on a real handshake.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_ACT   = 2'b01,
    OP_BLK   = 2'b10,
    OP_UNBLK = 2'b11
  } cmd_op_e;
endpackage

// File: rtl/sched_events.sv
// Turns the command and all hardware events of one cycle into per-task
// set/clear vectors (R3, R4, R5, R9).
module sched_events
  import sched_pkg::*;
#(
  parameter int NT  = 16,
  parameter int NTH = 9,
  parameter int NCH = 4,
  parameter int TW  = 4
) (
  input  logic [1:0]      cmd_op,
  input  logic [TW-1:0]   cmd_task,
  input  logic [NCH-1:0]  chan_word,
  input  logic [NCH*TW-1:0] chan_map,
  input  logic [NTH-1:0]  thr_done,
  input  logic [NTH*TW-1:0] thr_map,
  input  logic [NTH-1:0]  thr_unblk,
  output logic [NT-1:0]   set_act,
  output logic [NT-1:0]   set_blk,
  output logic [NT-1:0]   clr_blk
);
  cmd_op_e op;
  assign op = cmd_op_e'(cmd_op);

  always_comb begin
    set_act = '0;
    set_blk = '0;
    clr_blk = '0;
    case (op)
      OP_ACT:   set_act[cmd_task] = 1'b1;
      OP_BLK:   set_blk[cmd_task] = 1'b1;
      OP_UNBLK: clr_blk[cmd_task] = 1'b1;
      default:  ;
    endcase
    for (int c = 0; c < NCH; c++) begin
      if (chan_word[c]) set_act[chan_map[c*TW +: TW]] = 1'b1;
    end
    for (int k = 0; k < NTH; k++) begin
      if (thr_done[k]) begin
        if (thr_unblk[k]) clr_blk[thr_map[k*TW +: TW]] = 1'b1;
        else              set_act[thr_map[k*TW +: TW]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sched_state.sv
// Per-task activated and blocked bits. Set terms win over clear terms.
module sched_state #(
  parameter int            NT      = 16,
  parameter logic [NT-1:0] RST_BLK = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] set_act,
  input  logic [NT-1:0] clr_act,
  input  logic [NT-1:0] set_blk,
  input  logic [NT-1:0] clr_blk,
  output logic [NT-1:0] act_q,
  output logic [NT-1:0] blk_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
      blk_q <= RST_BLK;
    end else begin
      act_q <= (act_q & ~clr_act) | set_act;
      blk_q <= (blk_q & ~clr_blk) | set_blk;
    end
  end
endmodule

// File: rtl/sched_pick.sv
// Two-class lowest-index selector (R6, R7).
module sched_pick #(
  parameter int NT = 16,
  parameter int TW = 4
) (
  input  logic [NT-1:0] elig,
  input  logic [NT-1:0] prio,
  output logic          any,
  output logic [TW-1:0] idx
);
  logic [NT-1:0] hi, cand, first;

  assign hi   = elig & prio;
  assign cand = (|hi) ? hi : elig;
  assign any  = |elig;

  for (genvar i = 0; i < NT; i++) begin : g_first
    if (i == 0) begin : g_lsb
      assign first[i] = cand[i];
    end else begin : g_rest
      assign first[i] = cand[i] & ~(|cand[i-1:0]);
    end
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NT; i++) begin
      if (first[i]) idx = idx | TW'(i);
    end
  end
endmodule

// File: rtl/task_sched.sv
module task_sched
  import sched_pkg::*;
#(
  parameter int                   NUM_TASKS     = 16,
  parameter int                   NUM_THREADS   = 9,
  parameter int                   NUM_CHANNELS  = 4,
  parameter logic [NUM_TASKS-1:0] RESET_BLOCKED = 16'hFF00,
  localparam int                  TID_W         = $clog2(NUM_TASKS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    cmd_op,
  input  logic [TID_W-1:0]              cmd_task,
  input  logic [NUM_CHANNELS-1:0]       chan_word,
  input  logic [NUM_CHANNELS*TID_W-1:0] chan_map,
  input  logic [NUM_THREADS-1:0]        thr_done,
  input  logic [NUM_THREADS*TID_W-1:0]  thr_map,
  input  logic [NUM_THREADS-1:0]        thr_unblk,
  input  logic [NUM_TASKS-1:0]          prio_mask,
  output logic                          disp_valid,
  input  logic                          disp_ready,
  output logic [TID_W-1:0]              disp_task,
  input  logic                          task_done
);
  logic [NUM_TASKS-1:0] set_act, set_blk, clr_blk, clr_act;
  logic [NUM_TASKS-1:0] act_w, blk_w, elig;
  logic                 any_elig, accept, busy_q;

  sched_events #(
    .NT(NUM_TASKS), .NTH(NUM_THREADS), .NCH(NUM_CHANNELS), .TW(TID_W)
  ) u_events (
    .cmd_op(cmd_op), .cmd_task(cmd_task),
    .chan_word(chan_word), .chan_map(chan_map),
    .thr_done(thr_done), .thr_map(thr_map), .thr_unblk(thr_unblk),
    .set_act(set_act), .set_blk(set_blk), .clr_blk(clr_blk)
  );

  sched_state #(.NT(NUM_TASKS), .RST_BLK(RESET_BLOCKED)) u_state (
    .clk(clk), .rst_n(rst_n),
    .set_act(set_act), .clr_act(clr_act),
    .set_blk(set_blk), .clr_blk(clr_blk),
    .act_q(act_w), .blk_q(blk_w)
  );

  assign elig = act_w & ~blk_w;

  sched_pick #(.NT(NUM_TASKS), .TW(TID_W)) u_pick (
    .elig(elig), .prio(prio_mask), .any(any_elig), .idx(disp_task)
  );

  assign disp_valid = any_elig & ~busy_q;
  assign accept     = disp_valid & disp_ready;

  always_comb begin
    clr_act = '0;
    if (accept) clr_act[disp_task] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 busy_q <= 1'b0;
    else if (accept)            busy_q <= 1'b1;
    else if (busy_q && task_done) busy_q <= 1'b0;
  end
endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
  parameter int NT = 16,
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          disp_valid,
  input logic          disp_ready,
  input logic [TW-1:0] disp_task,
  input logic          task_done,
  input logic [NT-1:0] prio_mask,
  input logic [NT-1:0] act,
  input logic [NT-1:0] blk,
  input logic          busy
);
  logic [NT-1:0] elig, cls, below;
  assign elig  = act & ~blk;
  assign cls   = prio_mask[disp_task] ? prio_mask : ~prio_mask;
  assign below = (NT'(1) << disp_task) - NT'(1);

  p_elig_r1: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (act[disp_task] && !blk[disp_task]));

  p_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && |(elig & prio_mask)) |-> prio_mask[disp_task]);

  p_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> ((elig & cls & below) == '0));

  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready) |=> (busy && !disp_valid));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && task_done) |=> !busy);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(disp_valid && disp_ready)) |=> !busy);
endmodule

bind task_sched sched_chk #(.NT(NUM_TASKS), .TW(TID_W)) u_sched_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .disp_task(disp_task), .task_done(task_done), .prio_mask(prio_mask),
  .act(act_w), .blk(blk_w), .busy(busy_q)
);

// File: tb/test_task_sched.sv
`timescale 1ns/1ps
module test_task_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [3:0]  cmd_task = '0;
  logic [3:0]  chan_word = '0;
  logic [15:0] chan_map;
  logic [8:0]  thr_done = '0;
  logic [35:0] thr_map;
  logic [8:0]  thr_unblk;
  logic [15:0] prio_mask;
  logic        disp_valid, disp_ready = 1'b0, task_done = 1'b0;
  logic [3:0]  disp_task;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // channels 3..0 -> tasks 9,6,5,3
  assign chan_map  = {4'd9, 4'd6, 4'd5, 4'd3};
  // threads 8..0 -> tasks 15,4,2,12,12,11,11,10,10
  assign thr_map   = {4'd15, 4'd4, 4'd2, 4'd12, 4'd12, 4'd11, 4'd11, 4'd10, 4'd10};
  // threads 1,3,4,8 unblock; the rest activate
  assign thr_unblk = 9'b1_0001_1010;
  assign prio_mask = 16'h8040;   // tasks 15 and 6 are high priority

  task_sched i_task_sched (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_task(cmd_task),
    .chan_word(chan_word), .chan_map(chan_map), .thr_done(thr_done),
    .thr_map(thr_map), .thr_unblk(thr_unblk), .prio_mask(prio_mask),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_task(disp_task),
    .task_done(task_done)
  );

  task automatic chk(input logic ev, input logic [3:0] et, input string tag);
    checks++;
    if (disp_valid !== ev || (ev && disp_task !== et)) begin
      failures++;
      $display("FAIL %s: valid=%0b task=%0d expected valid=%0b task=%0d",
               tag, disp_valid, disp_task, ev, et);
    end
  endtask

  // Apply inputs for one edge, then return them to idle 1 ns after the edge.
  task automatic step(input logic [1:0] op, input logic [3:0] tk, input logic [3:0] ch,
                      input logic [8:0] th, input logic r, input logic d);
    cmd_op = op; cmd_task = tk; chan_word = ch; thr_done = th;
    disp_ready = r; task_done = d;
    @(posedge clk); #1;
    cmd_op = '0; cmd_task = '0; chan_word = '0; thr_done = '0;
    disp_ready = 1'b0; task_done = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  // {op[25:24], task[23:20], chan[19:16], thr[15:7], ready[6], done[5], exp_valid[4], exp_task[3:0]}
  localparam logic [25:0] TBL [18] = '{
    {2'd0, 4'd0,  4'b0000, 9'h000, 1'b0, 1'b0, 1'b0, 4'd0 },  // R1 nothing pending
    {2'd0, 4'd0,  4'b0010, 9'h000, 1'b0, 1'b0, 1'b1, 4'd5 },  // R4 ch1 -> task 5
    {2'd0, 4'd0,  4'b0001, 9'h000, 1'b0, 1'b0, 1'b1, 4'd3 },  // R7 3 beats 5
    {2'd0, 4'd0,  4'b0100, 9'h000, 1'b0, 1'b0, 1'b1, 4'd6 },  // R6 prio 6 beats 3
    {2'd0, 4'd0,  4'b0000, 9'h001, 1'b0, 1'b0, 1'b1, 4'd6 },  // R5 act 10, still blocked
    {2'd0, 4'd0,  4'b0000, 9'h000, 1'b1, 1'b0, 1'b0, 4'd0 },  // R8 accept 6
    {2'd0, 4'd0,  4'b0000, 9'h000, 1'b0, 1'b1, 1'b1, 4'd3 },  // R8 done -> 3
    {2'd0, 4'd0,  4'b0000, 9'h000, 1'b1, 1'b0, 1'b0, 4'd0 },  // R8 accept 3
    {2'd0, 4'd0,  4'b0000, 9'h002, 1'b0, 1'b1, 1'b1, 4'd5 },  // R5 unblock 10, 5 lower
    {2'd2, 4'd5,  4'b0000, 9'h000, 1'b0, 1'b0, 1'b1, 4'd10},  // R3 block 5
    {2'd0, 4'd0,  4'b0000, 9'h000, 1'b1, 1'b0, 1'b0, 4'd0 },  // R8 accept 10
    {2'd0, 4'd0,  4'b0000, 9'h000, 1'b0, 1'b1, 1'b0, 4'd0 },  // R3 only blocked 5 left
    {2'd3, 4'd5,  4'b0000, 9'h000, 1'b0, 1'b0, 1'b1, 4'd5 },  // R3 unblock 5
    {2'd0, 4'd0,  4'b0000, 9'h030, 1'b0, 1'b0, 1'b1, 4'd5 },  // R9 barrier on 12 same cycle
    {2'd0, 4'd0,  4'b0000, 9'h000, 1'b1, 1'b0, 1'b0, 4'd0 },  // R8 accept 5
    {2'd0, 4'd0,  4'b0000, 9'h000, 1'b0, 1'b1, 1'b1, 4'd12},  // R9 12 now runs
    {2'd0, 4'd0,  4'b0000, 9'h000, 1'b1, 1'b0, 1'b0, 4'd0 },  // R8 accept 12
    {2'd0, 4'd0,  4'b0000, 9'h000, 1'b0, 1'b1, 1'b0, 4'd0 }   // R8 nothing left
  };

  initial begin
    do_reset();
    chk(1'b0, 4'd0, "R2 idle after reset");

    for (int i = 0; i < 18; i++) begin
      step(TBL[i][25:24], TBL[i][23:20], TBL[i][19:16], TBL[i][15:7], TBL[i][6], TBL[i][5]);
      chk(TBL[i][4], TBL[i][3:0], $sformatf("table step %0d (R1 R3 R4 R5 R6 R7 R8 R9)", i));
    end

    // Directed: reset-blocked tasks, conflicts, handshake corners
    do_reset();
    chk(1'b0, 4'd0, "R2 idle after second reset");
    step(2'd1, 4'd8, 4'b0, 9'h000, 1'b0, 1'b0);
    chk(1'b0, 4'd0, "R2 task 8 starts blocked");
    step(2'd3, 4'd8, 4'b0, 9'h000, 1'b0, 1'b0);
    chk(1'b1, 4'd8, "R3 unblock 8");
    // thr2 activates 11, thr3 unblocks 11, command blocks 11: block wins
    step(2'd2, 4'd11, 4'b0, 9'h00C, 1'b0, 1'b0);
    chk(1'b1, 4'd8, "R9 block beats unblock");
    step(2'd2, 4'd8, 4'b0, 9'h000, 1'b0, 1'b0);
    chk(1'b0, 4'd0, "R9 11 still blocked");
    step(2'd3, 4'd11, 4'b0, 9'h000, 1'b0, 1'b0);
    chk(1'b1, 4'd11, "R9 activation kept");
    step(2'd1, 4'd15, 4'b0, 9'h100, 1'b0, 1'b0);
    chk(1'b1, 4'd15, "R6 prio 15 beats 11");
    step(2'd0, 4'd0, 4'b0, 9'h000, 1'b1, 1'b1);
    chk(1'b0, 4'd0, "R10 done while idle ignored");
    step(2'd0, 4'd0, 4'b0, 9'h000, 1'b0, 1'b1);
    chk(1'b1, 4'd11, "R8 next offer right after done");
    step(2'd1, 4'd11, 4'b0, 9'h000, 1'b1, 1'b0);
    chk(1'b0, 4'd0, "R8 busy after accept");
    step(2'd0, 4'd0, 4'b0, 9'h000, 1'b0, 1'b1);
    chk(1'b1, 4'd11, "R8 re-activation during accept kept");
    step(2'd0, 4'd0, 4'b0, 9'h000, 1'b1, 1'b0);
    step(2'd0, 4'd0, 4'b0, 9'h000, 1'b0, 1'b1);
    chk(1'b0, 4'd0, "R8 activated bit cleared");
    step(2'd0, 4'd0, 4'b0, 9'h000, 1'b1, 1'b0);
    chk(1'b0, 4'd0, "R10 ready without offer");
    step(2'd3, 4'd8, 4'b0, 9'h000, 1'b0, 1'b0);
    chk(1'b1, 4'd8, "R10 stray ready did not make busy");
    step(2'd0, 4'd0, 4'b1000, 9'h000, 1'b0, 1'b0);
    chk(1'b1, 4'd8, "R4 ch3 task 9 blocked");
    step(2'd3, 4'd9, 4'b0, 9'h000, 1'b0, 1'b0);
    chk(1'b1, 4'd8, "R7 8 beats 9");

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule